// File: doc/BRIEF.md
# Layer Address Decoder with Fallback Slave

This block is the central address decoder for one layer of a two-layer AHB-style interconnect. It watches the address and transfer type of whichever master currently owns the layer. It compares that address against a parameterised table of slave regions, where each region is a base address plus a power-of-two size, and produces one-hot chip selects. The chip selects cover every slave on both layers, so a master on this layer can reach a slave on the other layer. The chip-select vector goes to a central arbiter, which steers the data path.

If the address falls in no region, the block selects its own built-in fallback slave. That slave answers idle and busy transfers with OKAY. It answers any real transfer, nonsequential or sequential, with the standard two-cycle ERROR response. The block registers the index of the selected slave on each address phase that the bus accepts, so a data-phase response multiplexer can use it.

Top module: `layer_addr_decoder`

## Requirements
- R1: In every cycle exactly one bit of {hsel_def_o, hsel_o} is high.
- R2: hsel_o[i] is high when haddr_i lies in [base_i, base_i + 2^size_i). The default map gives slave i (i < 15) base i<<24 and size 2^24, and gives slave 15 base 0x0E00_0000 and size 2^25.
- R3: When regions overlap, the lowest-numbered matching slave is selected. With the default map, addresses 0x0E00_0000 to 0x0EFF_FFFF go to slave 14, and 0x0F00_0000 to 0x0FFF_FFFF go to slave 15.
- R4: hsel_def_o is high exactly when no region matches. With the default map this is any address at or above 0x1000_0000.
- R5: On a clock edge where hready_i is high, dsel_idx_o takes the index of the selected slave. The fallback slave has index N_SLV, which is 16 by default. On an edge where hready_i is low, dsel_idx_o holds its value.
- R6: A transfer accepted by the fallback slave with htrans_i of IDLE (2'b00) or BUSY (2'b01) is followed by def_hready_o=1 and def_hresp_o=OKAY (0).
- R7: A transfer accepted by the fallback slave with htrans_i of NONSEQ (2'b10) or SEQ (2'b11) produces one cycle with def_hready_o=0 and def_hresp_o=ERROR (1), then one cycle with def_hready_o=1 and def_hresp_o=ERROR.
- R8: After reset, dsel_idx_o equals N_SLV, def_hready_o is 1 and def_hresp_o is OKAY.
- R9: A transfer accepted by a real slave leaves the fallback response at def_hready_o=1 and OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| haddr_i | input | ADDR_W | Address of the owning master |
| htrans_i | input | 2 | Transfer type of the owning master |
| hready_i | input | 1 | Bus-level ready; an address phase is accepted when high |
| hsel_o | output | N_SLV | One-hot chip selects for slaves of both layers |
| hsel_def_o | output | 1 | Fallback slave selected |
| dsel_idx_o | output | $clog2(N_SLV+1) | Data-phase slave index (N_SLV means fallback) |
| def_hready_o | output | 1 | Fallback slave ready |
| def_hresp_o | output | 1 | Fallback slave response (0 OKAY, 1 ERROR) |

## Verification
A wrong region mask or a wrong priority shows up on hsel_o in the same cycle as the address that triggers it. A corrupted registered index shows up on dsel_idx_o one edge after the next accepted address phase. It also shows when dsel_idx_o moves while hready_i is low. A fault in the fallback state machine appears on def_hready_o and def_hresp_o within one or two cycles of an unmapped transfer: a missing wait cycle, an ERROR sent for an idle transfer, or a response that sticks.

// File: rtl/lad_pkg.sv
package lad_pkg;
  localparam int unsigned DEF_N  = 16;
  localparam int unsigned DEF_AW = 32;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'b00,
    TR_BUSY   = 2'b01,
    TR_NONSEQ = 2'b10,
    TR_SEQ    = 2'b11
  } htrans_e;

  localparam logic RESP_OKAY  = 1'b0;
  localparam logic RESP_ERROR = 1'b1;

  typedef enum logic [1:0] {
    DS_IDLE = 2'b00,
    DS_ERR1 = 2'b01,
    DS_ERR2 = 2'b10
  } dslv_st_e;

  // slaves 0..14 on 16 MiB steps; slave 15 spans 32 MiB overlapping slave 14
  function automatic logic [DEF_N-1:0][DEF_AW-1:0] def_base();
    logic [DEF_N-1:0][DEF_AW-1:0] b;
    for (int i = 0; i < DEF_N - 1; i++) b[i] = DEF_AW'(i) << 24;
    b[DEF_N-1] = 32'h0E00_0000;
    return b;
  endfunction

  function automatic logic [DEF_N-1:0][7:0] def_size();
    logic [DEF_N-1:0][7:0] s;
    for (int i = 0; i < DEF_N - 1; i++) s[i] = 8'd24;
    s[DEF_N-1] = 8'd25;
    return s;
  endfunction
endpackage

// File: rtl/lad_region_match.sv
module lad_region_match #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned N_SLV  = 16,
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_BASE = '0,
  parameter logic [N_SLV-1:0][7:0]        SLV_SIZE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_SLV-1:0]  match_o
);
  for (genvar g = 0; g < N_SLV; g++) begin : g_rgn
    localparam int unsigned SZ = int'(SLV_SIZE[g]);
    localparam logic [ADDR_W-1:0] MSK =
      (SZ >= ADDR_W) ? '0 : ~((ADDR_W'(1) << SZ) - ADDR_W'(1));
    assign match_o[g] = (addr_i & MSK) == (SLV_BASE[g] & MSK);
  end
endmodule

// File: rtl/lad_prio_sel.sv
module lad_prio_sel #(
  parameter int unsigned N_SLV = 16,
  localparam int unsigned IDX_W = $clog2(N_SLV + 1)
) (
  input  logic [N_SLV-1:0] match_i,
  output logic [N_SLV-1:0] grant_o,
  output logic             none_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest set bit wins
  assign grant_o = match_i & (~match_i + N_SLV'(1));
  assign none_o  = ~|match_i;

  always_comb begin
    idx_o = IDX_W'(N_SLV);
    for (int i = N_SLV - 1; i >= 0; i--)
      if (match_i[i]) idx_o = IDX_W'(i);
  end
endmodule

// File: rtl/lad_default_slave.sv
module lad_default_slave
  import lad_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_i,
  input  logic [1:0] htrans_i,
  input  logic       hready_i,
  output logic       hready_o,
  output logic       hresp_o
);
  dslv_st_e st_q, st_d;
  logic     err_acc;

  // nonseq/seq have htrans[1] set
  assign err_acc = sel_i & hready_i & htrans_i[1];

  always_comb begin
    unique case (st_q)
      DS_ERR1: st_d = DS_ERR2;
      default: st_d = err_acc ? DS_ERR1 : DS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= DS_IDLE;
    else         st_q <= st_d;

  assign hready_o = (st_q != DS_ERR1);
  assign hresp_o  = (st_q == DS_IDLE) ? RESP_OKAY : RESP_ERROR;

  AST_WAIT_IS_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |-> hresp_o == RESP_ERROR);                               // R7
  AST_ERROR_TWO_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_o |=> hready_o && hresp_o == RESP_ERROR);                   // R7
  AST_ERR_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && hready_i && hready_o && htrans_i[1]) |=> !hready_o);      // R7
  AST_IDLE_OKAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && hready_i && hready_o && !htrans_i[1]) |=> hready_o && hresp_o == RESP_OKAY); // R6
endmodule

// File: rtl/layer_addr_decoder.sv
module layer_addr_decoder
  import lad_pkg::*;
#(
  parameter int unsigned ADDR_W = lad_pkg::DEF_AW,
  parameter int unsigned N_SLV  = lad_pkg::DEF_N,
  parameter logic [N_SLV-1:0][ADDR_W-1:0] SLV_BASE = lad_pkg::def_base(),
  parameter logic [N_SLV-1:0][7:0]        SLV_SIZE = lad_pkg::def_size(),
  localparam int unsigned IDX_W = $clog2(N_SLV + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] haddr_i,
  input  logic [1:0]        htrans_i,
  input  logic              hready_i,
  output logic [N_SLV-1:0]  hsel_o,
  output logic              hsel_def_o,
  output logic [IDX_W-1:0]  dsel_idx_o,
  output logic              def_hready_o,
  output logic              def_hresp_o
);
  localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(N_SLV);

  logic [N_SLV-1:0] match;
  logic [IDX_W-1:0] idx_a;
  logic [IDX_W-1:0] dsel_q;

  lad_region_match #(
    .ADDR_W(ADDR_W), .N_SLV(N_SLV), .SLV_BASE(SLV_BASE), .SLV_SIZE(SLV_SIZE)
  ) u_match (
    .addr_i (haddr_i),
    .match_o(match)
  );

  lad_prio_sel #(.N_SLV(N_SLV)) u_prio (
    .match_i(match),
    .grant_o(hsel_o),
    .none_o (hsel_def_o),
    .idx_o  (idx_a)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)       dsel_q <= DEF_IDX;
    else if (hready_i) dsel_q <= idx_a;

  assign dsel_idx_o = dsel_q;

  lad_default_slave u_def (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (hsel_def_o),
    .htrans_i(htrans_i),
    .hready_i(hready_i),
    .hready_o(def_hready_o),
    .hresp_o (def_hresp_o)
  );

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({hsel_def_o, hsel_o}) == 1);                             // R1
  AST_DEF_WHEN_NO_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match == '0) |-> hsel_def_o);                                      // R4
  AST_LOWEST_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((hsel_o & match) == hsel_o) && ((hsel_o - N_SLV'(1)) & match) == '0); // R3
  AST_DSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hready_i |=> $stable(dsel_idx_o));                                 // R5
  AST_DSEL_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dsel_idx_o <= DEF_IDX);                                             // R5
  AST_REAL_SLV_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hready_i && !hsel_def_o && def_hready_o) |=> def_hready_o && !def_hresp_o); // R9
endmodule

// File: tb/layer_addr_decoder_tb.sv
`timescale 1ns/1ps
module layer_addr_decoder_tb;
  localparam int N = 16;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] haddr = '0;
  logic [1:0]  htrans = '0;
  logic        hready = 1'b1;
  logic [N-1:0] hsel;
  logic        hsel_def;
  logic [4:0]  dsel;
  logic        def_rdy, def_resp;

  int n_chk = 0, n_bad = 0;
  int exp_dsel;
  int exp_st;   // 0 idle, 1 wait-error, 2 final-error
  bit done = 0;

  always #4 clk = ~clk;

  layer_addr_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .haddr_i(haddr), .htrans_i(htrans),
    .hready_i(hready), .hsel_o(hsel), .hsel_def_o(hsel_def),
    .dsel_idx_o(dsel), .def_hready_o(def_rdy), .def_hresp_o(def_resp)
  );

  function automatic logic [31:0] tb_base(int i);
    return (i == 15) ? 32'h0E00_0000 : (32'(i) << 24);
  endfunction
  function automatic int tb_size(int i);
    return (i == 15) ? 25 : 24;
  endfunction
  function automatic int ref_idx(logic [31:0] a);
    for (int i = 0; i < N; i++) begin
      logic [31:0] lo = tb_base(i);
      logic [32:0] hi = {1'b0, lo} + (33'd1 << tb_size(i));
      if (a >= lo && {1'b0, a} < hi) return i;
    end
    return N;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_resp(string req);
    chk(def_rdy == (exp_st != 1), req, def_rdy, exp_st != 1);
    chk(def_resp == (exp_st != 0), req, def_resp, exp_st != 0);
  endtask

  // one bus cycle: drive at negedge, check decode, clock, check registered state
  task automatic step(logic [31:0] a, logic [1:0] t, bit slv_rdy);
    int r;
    logic [N-1:0] exp_sel;
    bit acc;
    @(negedge clk);
    haddr = a; htrans = t;
    hready = (exp_dsel == N) ? (exp_st != 1) : slv_rdy;
    #1;
    r = ref_idx(a);
    exp_sel = (r == N) ? '0 : (N'(1) << r);
    chk($countones({hsel_def, hsel}) == 1, "R1", {hsel_def, hsel}, 1);
    if (a[31:24] == 8'h0E) chk(hsel == exp_sel, "R3", hsel, exp_sel);
    else                   chk(hsel == exp_sel, "R2", hsel, exp_sel);
    chk(hsel_def == (r == N), "R4", hsel_def, r == N);
    acc = hready;
    if (exp_st == 1) exp_st = 2;
    else exp_st = (acc && r == N && t[1]) ? 1 : 0;
    if (acc) exp_dsel = r;
    @(posedge clk); #1;
    chk(dsel == 5'(exp_dsel), acc ? "R5" : "R5_hold", dsel, exp_dsel);
    if (acc && r == N && t[1])      check_resp("R7");
    else if (acc && r == N)         check_resp("R6");
    else if (acc)                   check_resp("R9");
    else                            check_resp("R7");
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    exp_dsel = N; exp_st = 0;
    repeat (3) @(posedge clk);
    #1;
    // R8 reset state
    chk(dsel == 5'(N), "R8", dsel, N);
    chk(def_rdy == 1'b1, "R8", def_rdy, 1);
    chk(def_resp == 1'b0, "R8", def_resp, 0);
    @(negedge clk); rst_n = 1;

    // directed boundaries R2/R3/R4
    step(32'h00FF_FFFF, 2'b10, 1);
    step(32'h0100_0000, 2'b11, 1);
    step(32'h0E00_0000, 2'b10, 1);
    step(32'h0EFF_FFFF, 2'b10, 1);
    step(32'h0F00_0000, 2'b10, 1);
    step(32'h0FFF_FFFF, 2'b10, 1);
    // R6 idle and busy to unmapped space
    step(32'h1000_0000, 2'b00, 1);
    step(32'hFFFF_FFFF, 2'b01, 1);
    // R7 back-to-back errors
    step(32'h2000_0000, 2'b10, 1);
    step(32'h2000_0004, 2'b11, 1);
    step(32'h2000_0008, 2'b11, 1);
    step(32'h2000_000C, 2'b00, 1);
    // R9 then R5 hold with stalled real slave
    step(32'h0300_0010, 2'b10, 1);
    step(32'h0500_0000, 2'b10, 0);
    step(32'hF000_0000, 2'b10, 0);
    step(32'h0500_0000, 2'b10, 1);

    for (int k = 0; k < 3000; k++) begin
      logic [31:0] a;
      int sel = $urandom_range(0, 19);
      if (sel < N) a = tb_base(sel) + ($urandom & ((32'd1 << tb_size(sel)) - 1));
      else         a = $urandom | 32'h1000_0000;
      step(a, 2'($urandom), ($urandom_range(0, 3) != 0));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule